// File: doc/BRIEF.md
# Byte-banked 16-bit bus cycle controller

This block turns simple access requests into four-clock bus cycles for a 16-bit processor whose memory is built from two byte-wide banks: an even bank on data bits 7:0 and an odd bank on data bits 15:8. The requester presents a 20-bit byte address, a read/write flag, a byte/word size and write data. The controller produces the address latch strobe, the active-low read and write strobes, a data-valid window, a direction flag and the two active-low bank enables. It moves request bytes onto the correct bank lane and gathers read bytes back into little-endian order.

A word at an odd address does not fit one bank pair. The controller therefore runs it as two back-to-back bus cycles. The first cycle places the low byte on the high lane at the odd address. The second places the high byte on the low lane at the next even address. The requester sees a single access that completes once.

The controller also handles reset. A processor reset request must stay high for a minimum number of clocks before it is accepted. While an accepted reset is held, any bus activity stops. When the reset is released, the first bus cycle is a word fetch from the top-of-memory start address.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: Every bus cycle lasts exactly four clocks, T1 to T4. `bus_ale` is high in T1 and low in T2, T3 and T4.
- R2: `bus_rd_n` (on reads) or `bus_wr_n` (on writes) is low in T2 and T3 and high in T1 and T4. The other strobe stays high. Both strobes are high when no cycle runs.
- R3: `bus_den` is high in T2 and T3 of both reads and writes, and low otherwise. `bus_oe` follows `bus_den` on writes and stays low on reads. `bus_dout` is all zero whenever `bus_oe` is low.
- R4: `bus_dir` is 1 throughout a write cycle and 0 throughout a read cycle, and does not change between T1 and T4.
- R5: Bank enables are active low. During a cycle, `bus_ble_n` equals address bit 0 and `bus_bhe_n` is 0 exactly when the cycle uses bits 15:8. With no cycle running, both are 1.
- R6: A word at an even address takes one cycle with both lanes enabled. `bus_dout` equals the write data, and read data is `bus_din` unchanged.
- R7: A word at odd address A takes two consecutive cycles with no idle cycle between them. The first cycle is at A on the high lane and carries the low byte on bits 15:8. The second is at A+1 (wrapping within 20 bits) on the low lane and carries the high byte on bits 7:0. The unused lane is zero. Read data returns as {byte at A+1, byte at A}.
- R8: A byte access takes one cycle. At an even address it uses the low lane; at an odd address it uses the high lane. The request byte is `req_wdata[7:0]` and `req_wdata[15:8]` is ignored. Read data returns the byte in bits 7:0 with bits 15:8 zero.
- R9: `req_ready` is high for one clock, in the final T4 of an access, and `rd_data` is valid in that clock. The cycle after that T4 is idle. No ready is given during the first cycle of a split access.
- R10: A `cpu_reset` high for fewer than 4 consecutive rising clock edges has no effect. After 4 consecutive high samples, the reset is accepted and held until `cpu_reset` falls.
- R11: After `rst_n` releases, and after an accepted `cpu_reset` falls, the first bus cycle is a word read at 0xFFFF0. It runs ahead of any pending request. Its data appears on `rd_data` with `fetch_valid` high in its T4, and `req_ready` stays low.
- R12: While an accepted reset is held, any running cycle is abandoned within one clock. `bus_ale` and `bus_den` stay low, the strobes stay high and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_reset | input | 1 | Processor reset request, active high, filtered by hold length |
| req_valid | input | 1 | Access request present |
| req_addr | input | 20 | Byte address of the access |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | 1 for 16-bit word, 0 for byte |
| req_wdata | input | 16 | Write data, little-endian; a byte uses bits 7:0 |
| req_ready | output | 1 | Access complete (final T4) |
| rd_data | output | 16 | Read result, ordered as a little-endian word |
| fetch_valid | output | 1 | Start-up fetch complete, data on rd_data |
| bus_addr | output | 20 | Bus address, held for the whole cycle |
| bus_ale | output | 1 | Address latch strobe (T1) |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_den | output | 1 | Data-valid window |
| bus_dir | output | 1 | Direction: 1 write, 0 read |
| bus_ble_n | output | 1 | Even bank enable, active low |
| bus_bhe_n | output | 1 | Odd bank enable, active low |
| bus_dout | output | 16 | Write data onto the bank lanes |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_din | input | 16 | Read data from the bank lanes |

## Verification
A request presented before a rising edge in the idle state makes that edge enter T1. The strobes and window then change on the following three edges. `req_ready` appears in the fourth clock, or the eighth for a split word, and the clock after that is idle. Read data is captured at the edge that ends T3, so it is already in `rd_data` during T4. The bench drives inputs and samples all outputs at falling edges. Each cycle is found by its address strobe and then walked through T1 to T4 one falling edge at a time, checking strobes, enables, lanes and completion in the clock where each is due. Reset filtering is timed by counting rising edges between the falling-edge writes of `cpu_reset`.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  // Which bank lanes a bus cycle uses
  typedef enum logic [1:0] {
    LN_BOTH = 2'd0,
    LN_LO   = 2'd1,
    LN_HI   = 2'd2
  } lane_e;
endpackage

// File: rtl/bcc_rst_filter.sv
module bcc_rst_filter #(
  parameter int HOLD_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_reset,
  output logic rst_sync_n,
  output logic hold_reset
);
  localparam int CW = $clog2(HOLD_MIN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  always_comb begin
    if (!cpu_reset)                    cnt_d = '0;
    else if (cnt_q == CW'(HOLD_MIN))   cnt_d = cnt_q;
    else                               cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  assign hold_reset = (cnt_q == CW'(HOLD_MIN));

  // R10: a low sample always clears acceptance on the next edge
  p_short_ignored_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cpu_reset |=> !hold_reset);
  // R10: acceptance only ever follows a high sample
  p_rise_needs_high_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hold_reset) |-> $past(cpu_reset));
endmodule

// File: rtl/bcc_tstate_seq.sv
module bcc_tstate_seq
  import bcc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    abort,
  input  logic    start,
  input  logic    again,
  output tstate_e st
);
  tstate_e st_d;

  always_comb begin
    unique case (st)
      TS_IDLE: st_d = start ? TS_T1 : TS_IDLE;
      TS_T1:   st_d = TS_T2;
      TS_T2:   st_d = TS_T3;
      TS_T3:   st_d = TS_T4;
      TS_T4:   st_d = again ? TS_T1 : TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
    if (abort) st_d = TS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= TS_IDLE;
    else        st <= st_d;
  end

  // R1: the four T-states follow each other without gaps
  p_t1_t2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TS_T1 && !abort) |=> st == TS_T2);
  p_t2_t3_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TS_T2 && !abort) |=> st == TS_T3);
  p_t3_t4_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TS_T3 && !abort) |=> st == TS_T4);
endmodule

// File: rtl/bcc_lane_steer.sv
module bcc_lane_steer
  import bcc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  lane_e             lane,
  input  logic              src_hi,
  input  logic              active,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_cur,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rd_next,
  output logic [1:0]        en_n
);
  localparam int LANES = 2;
  localparam int BW    = DATA_W / LANES;

  logic [BW-1:0] src_byte, sel_byte;

  // byte taken from the request for a single-lane write
  assign src_byte = src_hi ? wdata[DATA_W-1:BW] : wdata[BW-1:0];
  // byte picked from the bus for a single-lane read
  assign sel_byte = (lane == LN_HI) ? din[DATA_W-1:BW] : din[BW-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic use_l;
    assign use_l = (l == 0) ? (lane != LN_HI) : (lane != LN_LO);
    assign en_n[l] = !(active && use_l);

    always_comb begin
      if (!use_l)               dout[l*BW +: BW] = '0;
      else if (lane == LN_BOTH) dout[l*BW +: BW] = wdata[l*BW +: BW];
      else                      dout[l*BW +: BW] = src_byte;

      if (lane == LN_BOTH)          rd_next[l*BW +: BW] = din[l*BW +: BW];
      else if (src_hi == 1'(l))     rd_next[l*BW +: BW] = sel_byte;
      else                          rd_next[l*BW +: BW] = rd_cur[l*BW +: BW];
    end
  end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 16,
  parameter int                HOLD_MIN  = 4,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'('hFFFF0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_reset,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_den,
  output logic              bus_dir,
  output logic              bus_ble_n,
  output logic              bus_bhe_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din
);
  logic    rst_sync_n, hold_reset;
  tstate_e st;

  // access context
  logic [ADDR_W-1:0] cur_addr, n_addr;
  logic              cur_wr, n_wr, cur_word, n_word, cur_boot, n_boot;
  logic              half2, n_half2, boot_pend, n_boot_pend;
  logic [DATA_W-1:0] wbuf, n_wbuf, rbuf, n_rbuf;
  logic              ctx_en, pend_en;

  logic              start, split, final_t4, active, strobe_win;
  lane_e             lane;
  logic [DATA_W-1:0] lane_dout, rd_next;
  logic [1:0]        en_n;

  bcc_rst_filter #(.HOLD_MIN(HOLD_MIN)) u_rst (
    .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset),
    .rst_sync_n(rst_sync_n), .hold_reset(hold_reset)
  );

  assign start    = (st == TS_IDLE) && !hold_reset && (boot_pend || req_valid);
  assign split    = cur_word && cur_addr[0] && !half2;
  assign final_t4 = (st == TS_T4) && !split && !hold_reset;

  bcc_tstate_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .abort(hold_reset),
    .start(start), .again(split), .st(st)
  );

  always_comb begin
    if (half2)                          lane = LN_LO;
    else if (cur_word && !cur_addr[0])  lane = LN_BOTH;
    else if (cur_addr[0])               lane = LN_HI;
    else                                lane = LN_LO;
  end

  assign active     = (st != TS_IDLE);
  assign strobe_win = (st == TS_T2) || (st == TS_T3);

  bcc_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .lane(lane), .src_hi(half2), .active(active),
    .wdata(wbuf), .din(bus_din), .rd_cur(rbuf),
    .dout(lane_dout), .rd_next(rd_next), .en_n(en_n)
  );

  // next-state for the access context
  always_comb begin
    n_addr  = cur_addr;
    n_wr    = cur_wr;
    n_word  = cur_word;
    n_boot  = cur_boot;
    n_half2 = half2;
    n_wbuf  = wbuf;
    n_rbuf  = rbuf;
    if (start) begin
      n_addr  = boot_pend ? BOOT_ADDR : req_addr;
      n_wr    = !boot_pend && req_wr;
      n_word  = boot_pend || req_word;
      n_boot  = boot_pend;
      n_half2 = 1'b0;
      n_wbuf  = req_wdata;
      n_rbuf  = '0;
    end else if (st == TS_T4 && split) begin
      n_half2 = 1'b1;
      n_addr  = cur_addr + ADDR_W'(1);
    end
    if (st == TS_T3 && !cur_wr) n_rbuf = rd_next;
    ctx_en = start || (st == TS_T4 && split) || (st == TS_T3 && !cur_wr);

    n_boot_pend = boot_pend;
    if (hold_reset)             n_boot_pend = 1'b1;
    else if (start && boot_pend) n_boot_pend = 1'b0;
    pend_en = hold_reset || start;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cur_addr <= '0;
      cur_wr   <= 1'b0;
      cur_word <= 1'b0;
      cur_boot <= 1'b0;
      half2    <= 1'b0;
      wbuf     <= '0;
      rbuf     <= '0;
    end else if (ctx_en) begin
      cur_addr <= n_addr;
      cur_wr   <= n_wr;
      cur_word <= n_word;
      cur_boot <= n_boot;
      half2    <= n_half2;
      wbuf     <= n_wbuf;
      rbuf     <= n_rbuf;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  boot_pend <= 1'b1;
    else if (pend_en) boot_pend <= n_boot_pend;
  end

  assign req_ready   = final_t4 && !cur_boot;
  assign fetch_valid = final_t4 && cur_boot;
  assign rd_data     = rbuf;
  assign bus_addr    = cur_addr;
  assign bus_ale     = (st == TS_T1);
  assign bus_rd_n    = !(strobe_win && !cur_wr);
  assign bus_wr_n    = !(strobe_win && cur_wr);
  assign bus_den     = strobe_win;
  assign bus_dir     = active && cur_wr;
  assign bus_oe      = strobe_win && cur_wr;
  assign bus_dout    = bus_oe ? lane_dout : '0;
  assign bus_ble_n   = en_n[0];
  assign bus_bhe_n   = en_n[1];

  // R1: no strobe or data window while the address is latched
  p_ale_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_ale |-> (bus_rd_n && bus_wr_n && !bus_den));
  // R2: read and write strobes never overlap
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!bus_rd_n && !bus_wr_n));
  // R2: a strobe follows every address latch that is not aborted
  p_ale_then_strobe_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_ale && !hold_reset) |=> (!bus_rd_n || !bus_wr_n));
  // R4: direction held through the cycle
  p_dir_stable_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st == TS_T2 || st == TS_T3 || st == TS_T4) |-> $stable(bus_dir));
  // R5: some bank is always enabled during a cycle, low bank tracks A0
  p_enable_any_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active |-> !(bus_ble_n && bus_bhe_n));
  p_ble_addr_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active |-> (bus_ble_n == bus_addr[0]));
  // R7: the back-to-back second half is even and low lane only
  p_half2_even_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st == TS_T1 && $past(st) == TS_T4) |-> (!bus_addr[0] && bus_bhe_n && !bus_ble_n));
  // R9: completion only right after a T3
  p_ready_after_t3_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_ready || fetch_valid) |-> ($past(st) == TS_T3));
  // R11: the start-up cycle reads the boot address
  p_boot_first_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st == TS_T1 && $past(boot_pend)) |-> (bus_addr == BOOT_ADDR && !bus_dir));
  // R12: an accepted reset empties the sequencer
  p_abort_idle_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_reset |=> (st == TS_IDLE));
endmodule

// File: tb/bus_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n, cpu_reset;
  logic        req_valid, req_wr, req_word;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready, fetch_valid;
  logic [15:0] rd_data;
  logic [19:0] bus_addr;
  logic        bus_ale, bus_rd_n, bus_wr_n, bus_den, bus_dir, bus_ble_n, bus_bhe_n, bus_oe;
  logic [15:0] bus_dout, bus_din;
  logic [19:0] lat_addr;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  bus_cycle_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset),
    .req_valid(req_valid), .req_addr(req_addr), .req_wr(req_wr),
    .req_word(req_word), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .fetch_valid(fetch_valid), .bus_addr(bus_addr),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_den(bus_den), .bus_dir(bus_dir), .bus_ble_n(bus_ble_n),
    .bus_bhe_n(bus_bhe_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din)
  );

  // memory model: byte value is a function of its address
  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  always @(negedge clk) if (bus_ale) lat_addr <= bus_addr;
  assign bus_din = {mb({lat_addr[19:1], 1'b1}), mb({lat_addr[19:1], 1'b0})};

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Find the next T1 and walk it through T4, one falling edge per state
  task automatic watch_cycle(output logic [19:0] a, output logic d, output logic bl,
                             output logic bh, output logic [15:0] wo,
                             output logic ok1, output logic ok2, output logic ok3,
                             output logic ok4, output logic rdy, output logic fv,
                             output logic [15:0] rdd);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (bus_ale) break;
    end
    ok1 = bus_ale;
    ok2 = bus_rd_n && bus_wr_n;
    ok3 = !bus_den && !bus_oe;
    a = bus_addr; d = bus_dir; bl = bus_ble_n; bh = bus_bhe_n;
    ok4 = 1'b1;
    wo = 16'h0;
    for (int t = 2; t <= 3; t++) begin
      @(negedge clk);
      ok1 &= !bus_ale;
      ok2 &= d ? (!bus_wr_n && bus_rd_n) : (!bus_rd_n && bus_wr_n);
      ok3 &= bus_den && (bus_oe == d);
      ok4 &= (bus_dir == d);
      wo = bus_dout;
    end
    @(negedge clk);
    ok1 &= !bus_ale;
    ok2 &= bus_rd_n && bus_wr_n;
    ok3 &= !bus_den && !bus_oe && (bus_dout == 16'h0);
    ok4 &= (bus_dir == d);
    rdy = req_ready; fv = fetch_valid; rdd = rd_data;
  endtask

  task automatic check_reset_state();
    rst_n = 1'b0; cpu_reset = 1'b0; req_valid = 1'b0;
    req_addr = '0; req_wr = 1'b0; req_word = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", bus_ale, 1'b0);
    chk("R2", {bus_rd_n, bus_wr_n}, 2'b11);
    chk("R5", {bus_ble_n, bus_bhe_n}, 2'b11);
    chk("R9", req_ready, 1'b0);
    chk("R3", {bus_den, bus_oe, bus_dout}, 18'h0);
  endtask

  task automatic check_boot(input logic from_por);
    logic [19:0] a; logic d, bl, bh, o1, o2, o3, o4, rdy, fv; logic [15:0] wo, rdd;
    if (from_por) rst_n = 1'b1;
    watch_cycle(a, d, bl, bh, wo, o1, o2, o3, o4, rdy, fv, rdd);
    chk("R11", a, 20'hFFFF0);
    chk("R11", d, 1'b0);
    chk("R11", {bl, bh}, 2'b00);
    chk("R1", o1, 1'b1);
    chk("R11", {fv, rdy}, 2'b10);
    chk("R11", rdd, {mb(20'hFFFF1), mb(20'hFFFF0)});
  endtask

  task automatic do_access(input logic [19:0] ad, input logic wr, input logic word,
                           input logic [15:0] wd);
    string tg; int ncyc;
    logic [19:0] ea, a; logic ebl, ebh; logic [15:0] edo, erd, wo, rdd;
    logic d, bl, bh, o1, o2, o3, o4, rdy, fv;
    tg   = word ? (ad[0] ? "R7" : "R6") : "R8";
    ncyc = (word && ad[0]) ? 2 : 1;
    @(negedge clk);
    req_addr = ad; req_wr = wr; req_word = word; req_wdata = wd; req_valid = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      ea = (c == 0) ? ad : ad + 20'd1;
      if (word && !ad[0])   begin ebl = 0; ebh = 0; edo = wd; end
      else if (word && c == 0) begin ebl = 1; ebh = 0; edo = {wd[7:0], 8'h00}; end
      else if (word)        begin ebl = 0; ebh = 1; edo = {8'h00, wd[15:8]}; end
      else if (ad[0])       begin ebl = 1; ebh = 0; edo = {wd[7:0], 8'h00}; end
      else                  begin ebl = 0; ebh = 1; edo = {8'h00, wd[7:0]}; end
      if (!wr) edo = 16'h0;
      watch_cycle(a, d, bl, bh, wo, o1, o2, o3, o4, rdy, fv, rdd);
      chk(tg, a, ea);
      chk("R1", o1, 1'b1);
      chk("R2", o2, 1'b1);
      chk("R3", o3, 1'b1);
      chk("R4", {o4, d}, {1'b1, wr});
      chk("R5", {bl, bh}, {ebl, ebh});
      chk(tg, wo, edo);
      chk("R9", rdy, (c == ncyc - 1));
      chk("R11", fv, 1'b0);
    end
    if (!wr) begin
      erd = word ? {mb(ad + 20'd1), mb(ad)} : {8'h00, mb(ad)};
      chk(tg, rdd, erd);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9", {bus_ale, req_ready}, 2'b00);
  endtask

  task automatic short_reset_pulse();
    int seen;
    seen = 0;
    @(negedge clk);
    cpu_reset = 1'b1;
    repeat (3) @(negedge clk);
    cpu_reset = 1'b0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (bus_ale) seen++;
    end
    chk("R10", seen, 0);
  endtask

  task automatic held_reset_abort();
    logic [19:0] a; logic d, bl, bh, o1, o2, o3, o4, rdy, fv; logic [15:0] wo, rdd;
    @(negedge clk);
    cpu_reset = 1'b1;
    @(negedge clk);
    req_addr = 20'h05432; req_wr = 1'b0; req_word = 1'b1; req_wdata = 16'h0; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk("R12", {bus_ale, bus_den, bus_rd_n, bus_wr_n, req_ready}, 5'b00110);
    end
    cpu_reset = 1'b0;
    check_boot(1'b0);
    watch_cycle(a, d, bl, bh, wo, o1, o2, o3, o4, rdy, fv, rdd);
    chk("R11", a, 20'h05432);
    chk("R9", {rdy, fv}, 2'b10);
    chk("R6", rdd, {mb(20'h05433), mb(20'h05432)});
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    check_reset_state();
    check_boot(1'b1);
    do_access(20'h12344, 1'b0, 1'b1, 16'h0000);
    do_access(20'h0ABC2, 1'b1, 1'b1, 16'hBEEF);
    do_access(20'h35557, 1'b0, 1'b1, 16'h0000);
    do_access(20'h00101, 1'b1, 1'b1, 16'hCAFE);
    do_access(20'hFFFFF, 1'b0, 1'b1, 16'h0000);
    do_access(20'h22220, 1'b0, 1'b0, 16'h0000);
    do_access(20'h22221, 1'b0, 1'b0, 16'h0000);
    do_access(20'h40010, 1'b1, 1'b0, 16'h12A5);
    do_access(20'h40011, 1'b1, 1'b0, 16'h34C3);
    short_reset_pulse();
    do_access(20'h00F0E, 1'b0, 1'b1, 16'h0000);
    held_reset_abort();
    do_access(20'h7777B, 1'b1, 1'b1, 16'h9A3C);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule